// File: doc/BRIEF.md
# SPI Flash Command Controller

This block is a register-mapped SPI host that runs one serial-flash command at a time. Software uses a byte-wide register port. It sets up a command opcode, a payload-out length and a response length, then fills a shared eight-byte buffer through one data window. Each data-window access auto-increments the buffer pointer. Setting the start bit makes the block do four things in order: lower chip select, shift out the opcode, shift out the payload bytes, and clock in the response bytes. It then raises chip select and clears the start bit.

The response bytes land in the same buffer, directly behind the payload bytes. After a command, software does three things. It rewinds the pointer, reads past the payload bytes, and collects the response. The lengths and the clock divisor are held in a small side bank. That bank is reached through an index register and a data register.

The serial interface is SPI mode 0. SCLK idles low, MOSI changes after a falling edge, MISO is sampled on a rising edge, and every byte goes most significant bit first. The SCLK half period is programmable.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: After synchronous reset, the pins and the register views read as follows. `spi_cs_n` is 1 and `spi_sclk` is 0. Offset 0x02 bit 0 (start) reads 0 and offset 0x03 bit 7 (busy) reads 0. The pointer at offset 0x0D bits 2:0 reads 0.
- R2: The opcode written at offset 0x00 is always the first byte on MOSI, sent MSB first. SCLK stays low while `spi_cs_n` is high, and MOSI does not change while SCLK is high.
- R3: Offset 0x0C is the buffer data window. A write stores the byte at the pointer, and a read returns the byte at the pointer. Each such access advances the pointer by one, modulo 8. The pointer reads back at offset 0x0D bits 2:0 and does not move when read there.
- R4: Writing a 1 to offset 0x02 bit 4 returns the pointer to 0.
- R5: The side bank is selected by writing an index to offset 0x1E. It is then read or written at offset 0x1F. Index 5 holds the payload-out length, index 6 holds the response length, and index 2 holds the divisor D. Each SCLK half period lasts D+1 clock cycles.
- R6: Writing a 1 to offset 0x02 bit 0 starts a command. That bit reads 1 until the command ends, and the hardware then clears it. Offset 0x03 bit 7 reads 1 while the serial engine is running. Both bits read 0 once the command is over.
- R7: `spi_cs_n` stays low for the whole command. The opcode goes out first, followed by the payload bytes from buffer slots 0 upward, and then one byte per response byte with MOSI held at 0. After that `spi_cs_n` rises.
- R8: The response byte with index j is stored in buffer slot (payload length + j).
- R9: The payload length is limited to 8. The response length is limited to 8 minus the effective payload length, so one command clocks at most 9 bytes.
- R10: While the start bit or busy reads 1, data-window accesses and pointer-clear writes are ignored.
- R11: A command with both lengths at 0 produces exactly 8 SCLK pulses, which carry only the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Each internal state shows up at the ports in its own way. A wrong buffer pointer appears on the next read of offset 0x0D or the next data-window read, one cycle after the strobe. A wrong byte counter or wrong length clamp changes the number of SCLK pulses between the falling and rising edges of chip select, which is visible as soon as the command ends. A wrong store address for response bytes puts known response bytes into the wrong slots, and that shows up when software reads the buffer back after the command. A start bit that is never cleared, or cleared too early, shows up at the next status poll, either as a poll that never finishes or as a short burst of SCLK pulses.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [4:0] A_OPCODE = 5'h00;
  localparam logic [4:0] A_CTRL2  = 5'h02;
  localparam logic [4:0] A_CTRL3  = 5'h03;
  localparam logic [4:0] A_DATA   = 5'h0C;
  localparam logic [4:0] A_PTR    = 5'h0D;
  localparam logic [4:0] A_INDEX  = 5'h1E;
  localparam logic [4:0] A_EXT    = 5'h1F;

  localparam logic [7:0] X_DIV = 8'd2;
  localparam logic [7:0] X_TX  = 8'd5;
  localparam logic [7:0] X_RX  = 8'd6;

  localparam int B_START = 0;
  localparam int B_CLR   = 4;
  localparam int B_BUSY  = 7;

  typedef enum logic [2:0] {
    E_IDLE, E_SHIFT, E_NEXT, E_FETCH, E_LATCH, E_DONE
  } eng_state_e;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine import spi_cmd_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [CW-1:0]    tx_n,
  input  logic [CW-1:0]    rx_n,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             done,
  output logic             fifo_re,
  output logic [PW-1:0]    fifo_raddr,
  input  logic [7:0]       fifo_rdata,
  output logic             fifo_we,
  output logic [PW-1:0]    fifo_waddr,
  output logic [7:0]       fifo_wdata,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  eng_state_e       st_q;
  logic [CW-1:0]    k_q, tx_q, last_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] hc_q;
  logic [7:0]       sh_q, rx_q;
  logic             sclk_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= E_IDLE; k_q <= '0; tx_q <= '0; last_q <= '0;
      bit_q <= '0; hc_q <= '0; sh_q <= '0; rx_q <= '0;
      sclk_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      unique case (st_q)
        E_IDLE: if (start) begin
          cs_q <= 1'b0; sh_q <= opcode; k_q <= '0;
          tx_q <= tx_n; last_q <= tx_n + rx_n;
          bit_q <= '0; hc_q <= '0; sclk_q <= 1'b0; st_q <= E_SHIFT;
        end
        E_SHIFT: begin
          if (hc_q == div) begin
            hc_q <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_q   <= {rx_q[6:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == 3'd7) st_q <= E_NEXT;
              else begin
                bit_q <= bit_q + 3'd1;
                sh_q  <= {sh_q[6:0], 1'b0};
              end
            end
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end
        E_NEXT: begin
          if (k_q == last_q) st_q <= E_DONE;
          else begin
            k_q <= k_q + 1'b1; bit_q <= '0; hc_q <= '0;
            if (k_q < tx_q) st_q <= E_FETCH;
            else begin sh_q <= '0; st_q <= E_SHIFT; end
          end
        end
        E_FETCH: st_q <= E_LATCH;
        E_LATCH: begin sh_q <= fifo_rdata; st_q <= E_SHIFT; end
        E_DONE:  begin cs_q <= 1'b1; st_q <= E_IDLE; end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  // A byte index above the payload length is a response byte
  assign fifo_we    = (st_q == E_NEXT) && (k_q > tx_q);
  assign fifo_waddr = PW'(k_q - 1'b1);
  assign fifo_wdata = rx_q;
  assign fifo_re    = (st_q == E_FETCH);
  assign fifo_raddr = PW'(k_q - 1'b1);

  assign busy = (st_q != E_IDLE);
  assign done = (st_q == E_DONE);
  assign cs_n = cs_q;
  assign sclk = sclk_q;
  assign mosi = sh_q[7];
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl import spi_cmd_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic [7:0]       opcode_q, index_q, txc_q, rxc_q;
  logic [DIV_W-1:0] div_q;
  logic             start_q, exec_q, rdsel_q;
  logic [PW-1:0]    ptr_q;
  logic [7:0]       rreg_q, rmux;
  logic             eng_busy, eng_done;
  logic             eng_re, eng_we;
  logic [PW-1:0]    eng_raddr, eng_waddr;
  logic [7:0]       eng_wdata, fifo_dout;
  logic [7:0]       tx_eff, rx_room, rx_eff;

  logic hold, host_we, host_re;
  assign hold    = exec_q | eng_busy;
  assign host_we = reg_wr && (reg_addr == A_DATA) && !hold;
  assign host_re = reg_rd && (reg_addr == A_DATA) && !hold;

  // Length limits so that payload plus response fit the buffer
  assign tx_eff  = (txc_q > DEPTH8) ? DEPTH8 : txc_q;
  assign rx_room = DEPTH8 - tx_eff;
  assign rx_eff  = (rxc_q > rx_room) ? rx_room : rxc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q <= '0; index_q <= '0; txc_q <= '0; rxc_q <= '0;
      div_q <= '0; start_q <= 1'b0; exec_q <= 1'b0; ptr_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (eng_done) exec_q <= 1'b0;
      if (host_we || host_re) ptr_q <= ptr_q + 1'b1;
      if (reg_wr) begin
        unique case (reg_addr)
          A_OPCODE: opcode_q <= reg_wdata;
          A_INDEX:  index_q  <= reg_wdata;
          A_CTRL2: if (!hold) begin
            if (reg_wdata[B_CLR]) ptr_q <= '0;
            if (reg_wdata[B_START]) begin exec_q <= 1'b1; start_q <= 1'b1; end
          end
          A_EXT: begin
            if (index_q == X_TX)  txc_q <= reg_wdata;
            if (index_q == X_RX)  rxc_q <= reg_wdata;
            if (index_q == X_DIV) div_q <= DIV_W'(reg_wdata);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rmux = '0;
    unique case (reg_addr)
      A_OPCODE: rmux = opcode_q;
      A_CTRL2:  rmux[B_START] = exec_q;
      A_CTRL3:  rmux[B_BUSY] = eng_busy;
      A_PTR:    rmux = 8'(ptr_q);
      A_INDEX:  rmux = index_q;
      A_EXT: begin
        if (index_q == X_TX)  rmux = txc_q;
        if (index_q == X_RX)  rmux = rxc_q;
        if (index_q == X_DIV) rmux = 8'(div_q);
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rreg_q <= '0; rdsel_q <= 1'b0;
    end else begin
      rdsel_q <= host_re;
      if (reg_rd) rreg_q <= rmux;
    end
  end
  assign reg_rdata = rdsel_q ? fifo_dout : rreg_q;

  spi_byte_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk   (clk),
    .we    (host_we | eng_we),
    .waddr (eng_we ? eng_waddr : ptr_q),
    .wdata (eng_we ? eng_wdata : reg_wdata),
    .re    (host_re | eng_re),
    .raddr (eng_re ? eng_raddr : ptr_q),
    .rdata (fifo_dout)
  );

  spi_shift_engine #(.DEPTH(DEPTH), .DIV_W(DIV_W)) eng_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start_q),
    .opcode     (opcode_q),
    .tx_n       (CW'(tx_eff)),
    .rx_n       (CW'(rx_eff)),
    .div        (div_q),
    .busy       (eng_busy),
    .done       (eng_done),
    .fifo_re    (eng_re),
    .fifo_raddr (eng_raddr),
    .fifo_rdata (fifo_dout),
    .fifo_we    (eng_we),
    .fifo_waddr (eng_waddr),
    .fifo_wdata (eng_wdata),
    .cs_n       (spi_cs_n),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .miso       (spi_miso)
  );
endmodule

// File: rtl/spi_cmd_ctrl_chk.sv
module spi_cmd_ctrl_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    reg_addr,
  input logic          reg_wr,
  input logic          spi_cs_n,
  input logic          spi_sclk,
  input logic          spi_mosi,
  input logic          exec_q,
  input logic          eng_busy,
  input logic [PW-1:0] ptr_q
);
  a_r7_cs_idle: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> spi_cs_n);

  a_r2_sclk_low_deselected: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r6_busy_implies_start: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> exec_q);

  a_r6_start_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_busy) |-> !exec_q);

  a_r10_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    (exec_q && reg_wr && (reg_addr == 5'h0C || reg_addr == 5'h02)) |=> $stable(ptr_q));
endmodule

bind spi_cmd_ctrl spi_cmd_ctrl_chk #(.PW(PW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .exec_q   (exec_q),
  .eng_busy (eng_busy),
  .ptr_q    (ptr_q)
);

// File: tb/spi_cmd_ctrl_tb_top.sv
module spi_cmd_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  spi_cmd_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_bad = 0;

  // Behavioural flash: free-running edge counters, per-command bases
  int  fidx = 0, fbase = 0, rcnt = 0, hicnt = 0;
  bit  cap [4096];
  always @(negedge spi_sclk) fidx++;
  always @(posedge spi_sclk) begin cap[rcnt % 4096] = spi_mosi; rcnt++; end
  always @(negedge clk) if (spi_sclk) hicnt++;

  function automatic logic [7:0] resp(int n);
    return 8'(8'h5A + n * 8'h13);
  endfunction
  function automatic logic [7:0] pay(logic [7:0] op, int i);
    return 8'(op + 8'h31 * (i + 1));
  endfunction

  always_comb begin
    logic [7:0] b;
    int rel;
    rel = fidx - fbase;
    b = resp(rel / 8);
    spi_miso = b[7 - (rel % 8)];
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
  endtask
  task automatic ext_wr(input logic [7:0] idx, input logic [7:0] v);
    bus_wr(5'h1E, idx); bus_wr(5'h1F, v);
  endtask

  task automatic wait_done();
    logic [7:0] a, b;
    for (int g = 0; g < 4000; g++) begin
      bus_rd(5'h02, a); bus_rd(5'h03, b);
      if (!a[0] && !b[7]) break;
    end
    check("R6 start and busy cleared", {a[0], b[7]}, 0);
  endtask

  function automatic logic [7:0] cap_byte(int base, int k);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[7 - i] = cap[(base + k * 8 + i) % 4096];
    return v;
  endfunction

  task automatic run_cmd(logic [7:0] op, int tx, int rx, int dv);
    int txe, rxe, rb, hb, nbits;
    logic [7:0] d;
    txe = (tx > 8) ? 8 : tx;
    rxe = (rx > 8 - txe) ? 8 - txe : rx;
    ext_wr(8'd5, 8'(tx)); ext_wr(8'd6, 8'(rx)); ext_wr(8'd2, 8'(dv));
    bus_wr(5'h00, op);
    bus_wr(5'h02, 8'h10);
    for (int i = 0; i < txe; i++) bus_wr(5'h0C, pay(op, i));
    fbase = fidx; rb = rcnt; hb = hicnt;
    bus_wr(5'h02, 8'h01);
    bus_rd(5'h02, d);
    check("R6 start bit reads 1", d[0], 1);
    wait_done();
    check("R7 cs high after command", spi_cs_n, 1);
    nbits = (1 + txe + rxe) * 8;
    if (tx == 0 && rx == 0) check("R11 opcode-only pulses", rcnt - rb, 8);
    else if (tx != txe || rx != rxe) check("R9 clamped pulse count", rcnt - rb, nbits);
    else check("R7 pulse count", rcnt - rb, nbits);
    check("R5 divisor high time", hicnt - hb, nbits * (dv + 1));
    check("R2 opcode first", cap_byte(rb, 0), op);
    for (int i = 0; i < txe; i++) check("R7 payload order", cap_byte(rb, 1 + i), pay(op, i));
    for (int j = 0; j < rxe; j++) check("R7 mosi low on response", cap_byte(rb, 1 + txe + j), 0);
    bus_wr(5'h02, 8'h10);
    for (int i = 0; i < txe; i++) bus_rd(5'h0C, d);
    for (int j = 0; j < rxe; j++) begin
      bus_rd(5'h0C, d);
      check("R8 response slot", d, resp(1 + txe + j));
    end
  endtask

  // {opcode, tx length, rx length, divisor}
  localparam logic [31:0] VEC [7] = '{
    {8'h03, 8'd3,  8'd4, 8'd1},
    {8'h02, 8'd5,  8'd0, 8'd0},
    {8'h9F, 8'd0,  8'd3, 8'd2},
    {8'h06, 8'd0,  8'd0, 8'd0},
    {8'h0B, 8'd8,  8'd0, 8'd1},
    {8'h55, 8'd5,  8'd7, 8'd0},
    {8'hAA, 8'd12, 8'd2, 8'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 cs_n", spi_cs_n, 1);
    check("R1 sclk", spi_sclk, 0);
    bus_rd(5'h02, d); check("R1 start bit", d[0], 0);
    bus_rd(5'h03, d); check("R1 busy bit", d[7], 0);
    bus_rd(5'h0D, d); check("R1 pointer", d[2:0], 0);

    // R3 pointer advance and wrap, R4 clear
    for (int i = 0; i < 3; i++) bus_wr(5'h0C, 8'hE0 + 8'(i));
    bus_rd(5'h0D, d); check("R3 pointer after 3 writes", d[2:0], 3);
    bus_rd(5'h0D, d); check("R3 pointer read has no side effect", d[2:0], 3);
    for (int i = 0; i < 6; i++) bus_wr(5'h0C, 8'hE3 + 8'(i));
    bus_rd(5'h0D, d); check("R3 pointer wraps", d[2:0], 1);
    bus_wr(5'h02, 8'h10);
    bus_rd(5'h0D, d); check("R4 pointer cleared", d[2:0], 0);
    bus_rd(5'h0C, d); check("R3 slot 0 data", d, 8'hE8);
    bus_rd(5'h0C, d); check("R3 slot 1 data", d, 8'hE1);

    // R5 side bank readback
    ext_wr(8'd5, 8'd7); ext_wr(8'd6, 8'd1);
    bus_wr(5'h1E, 8'd5); bus_rd(5'h1F, d); check("R5 tx length readback", d, 7);
    bus_wr(5'h1E, 8'd6); bus_rd(5'h1F, d); check("R5 rx length readback", d, 1);

    foreach (VEC[v]) run_cmd(VEC[v][31:24], int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));

    // R10 accesses ignored during a command
    ext_wr(8'd5, 8'd1); ext_wr(8'd6, 8'd1); ext_wr(8'd2, 8'd10);
    bus_wr(5'h00, 8'h77);
    bus_wr(5'h02, 8'h10);
    bus_wr(5'h0C, 8'h3D);
    fbase = fidx;
    bus_wr(5'h02, 8'h01);
    bus_rd(5'h03, d); check("R6 busy during command", d[7], 1);
    bus_wr(5'h0C, 8'hFF);
    bus_wr(5'h02, 8'h10);
    wait_done();
    bus_rd(5'h0D, d); check("R10 pointer untouched while busy", d[2:0], 1);
    bus_wr(5'h02, 8'h10);
    bus_rd(5'h0C, d); check("R10 payload slot not overwritten", d, 8'h3D);
    bus_rd(5'h0C, d); check("R8 response after payload", d, resp(2));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule